// File: doc/BRIEF.md
# Sequential Read Prefetch Buffer with Hold and Flush Control

This block sits between a core's read port and an external bus. The core asks for one word at a time. If the word is already held in a small tagged buffer, the block answers at once. If not, the block reads it from the bus. After each demand access it keeps reading the next sequential word addresses in the background until the buffer is full, so a core that walks memory upward mostly hits.

Software drives prefetching through one control register with two live bits. The hold bit stops new background reads and keeps what is already buffered. The flush bit empties the buffer. A clear request reads back as 1 until it is done and then drops to 0 by itself. The usual sequence is to set hold, then flush (or both in one write), then release hold.

All three data paths use valid/ready. The core request is taken only in a cycle where `req_valid` and `req_ready` are both high. A response stays valid with stable data until `rsp_ready` is seen. A bus request holds its address until `bus_req_ready`. `bus_rsp_ready` is high only while a bus read is outstanding, and there is never more than one outstanding bus read.

Top module: `pfb_ctrl_top`

## Requirements
- R1: After reset the control read-back is 0, `req_ready` is 1, and neither `bus_req_valid` nor `rsp_valid` is asserted.
- R2: A demand read that misses issues a bus read of that address and returns the bus data to the core. A pending bus request keeps valid high and its address stable until `bus_req_ready`.
- R3: A demand read that matches a buffered entry is answered in the cycle after acceptance with the buffered word, and no bus read is made for it.
- R4: With hold clear, after a demand access the block reads the following sequential addresses until 4 words are buffered. It never holds more than 4 words and never has more than one bus read outstanding.
- R5: While the hold bit (control bit 0) is 1, no prefetch bus read starts. Demand misses still go to the bus.
- R6: Setting hold leaves buffered words in place, and they still serve hits.
- R7: Writing 1 to the flush bit (control bit 1) empties the buffer, so the next demand read misses. Prefetching starts again only after a later demand access.
- R8: The flush bit reads 1 while clearing is in progress, including while a prefetch read is still outstanding, and returns to 0 by itself when done.
- R9: A single write of 0x03 (hold and flush together) is accepted: the buffer is cleared and hold stays set.
- R10: Data returned for a prefetch read that was outstanding when a flush took effect is discarded and never served as a hit.
- R11: Control bits 7..2 read as 0, and writes to them have no effect.
- R12: While `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` does not change.
- R13: A demand miss to a non-sequential address drops the buffered words and restarts prefetching from the address after the missed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | CW | Control write data: bit 0 hold, bit 1 flush |
| ctl_rd_data | output | CW | Control read-back |
| req_valid | input | 1 | Core read request valid |
| req_ready | output | 1 | Core read request accepted when high with valid |
| req_addr | input | AW | Core word address |
| rsp_valid | output | 1 | Core read response valid |
| rsp_ready | input | 1 | Core accepts response |
| rsp_data | output | DW | Core read data |
| bus_req_valid | output | 1 | Bus read request valid |
| bus_req_ready | input | 1 | Bus accepts read request |
| bus_req_addr | output | AW | Bus read word address |
| bus_rsp_valid | input | 1 | Bus read data valid |
| bus_rsp_ready | output | 1 | Block accepts bus read data |
| bus_rsp_data | input | DW | Bus read data |

## Verification
The bound checker watches the handshake rules on every cycle: request stability on the bus, response stability toward the core, a single outstanding bus read, the 4-entry bound, the buffer being empty behind a pending flush, and no prefetch launch while hold is set. Whether a word was really answered from the buffer, whether the right sequential addresses were fetched, whether discarded data stays out, and whether prefetching restarts only after a new demand depend on histories of accesses. Only the bench's scenarios can show those, by counting bus reads and comparing returned data and hit latency against the expected memory contents.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_REQ  = 2'd1,
    BUS_WAIT = 2'd2
  } bus_st_t;

  // Control register bit positions
  localparam int CTL_HOLD_BIT  = 0;
  localparam int CTL_FLUSH_BIT = 1;
endpackage

// File: rtl/pfb_ctl_reg.sv
module pfb_ctl_reg
  import pfb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          flush_done,
  output logic          hold,
  output logic          flush_pend,
  output logic [CW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= 1'b0;
      flush_pend <= 1'b0;
    end else begin
      if (wr_en) hold <= wr_data[CTL_HOLD_BIT];
      if (wr_en && wr_data[CTL_FLUSH_BIT]) flush_pend <= 1'b1;
      else if (flush_done)                 flush_pend <= 1'b0;
    end
  end

  // Only the two live bits are returned; all others read zero.
  always_comb begin
    rd_data                = '0;
    rd_data[CTL_HOLD_BIT]  = hold;
    rd_data[CTL_FLUSH_BIT] = flush_pend;
  end
endmodule

// File: rtl/pfb_store.sv
// Circular tagged buffer; entries are kept in fetch order from head.
// DEPTH must be a power of two so pointers wrap naturally.
module pfb_store #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [AW-1:0]                lookup_addr,
  input  logic                         pop_en,
  input  logic                         push_en,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  output logic                         hit,
  output logic [DW-1:0]                hit_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH+1);

  logic [AW-1:0]   tag_q  [DEPTH];
  logic [DW-1:0]   data_q [DEPTH];
  logic [PW-1:0]   head_q;
  logic [CNTW-1:0] cnt_q;
  logic [DEPTH-1:0] match;
  logic [PW-1:0]   hit_idx;
  logic [PW-1:0]   tail;
  logic [CNTW-1:0] pop_n;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [PW-1:0] slot;
    assign slot     = head_q + PW'(i);
    assign match[i] = (CNTW'(i) < cnt_q) && (tag_q[slot] == lookup_addr);
  end

  // Oldest matching entry wins.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = PW'(i);
      end
    end
  end

  assign hit_data = data_q[head_q + hit_idx];
  assign tail     = head_q + cnt_q[PW-1:0];
  assign pop_n    = CNTW'(hit_idx) + CNTW'(1);
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (push_en) begin
      tag_q[tail]  <= push_addr;
      data_q[tail] <= push_data;
    end
  end

  // A hit retires the matched word and every older one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      cnt_q <= '0;
    end else begin
      if (pop_en && hit) head_q <= head_q + hit_idx + PW'(1);
      cnt_q <= cnt_q - ((pop_en && hit) ? pop_n : CNTW'(0))
                     + (push_en ? CNTW'(1) : CNTW'(0));
    end
  end
endmodule

// File: rtl/pfb_ctrl_top.sv
module pfb_ctrl_top
  import pfb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr_en,
  input  logic [CW-1:0] ctl_wr_data,
  output logic [CW-1:0] ctl_rd_data,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic [AW-1:0] bus_req_addr,
  input  logic          bus_rsp_valid,
  output logic          bus_rsp_ready,
  input  logic [DW-1:0] bus_rsp_data
);
  localparam int CNTW = $clog2(DEPTH+1);

  logic            hold, flush_pend, flush_done;
  bus_st_t         st_q;
  logic [AW-1:0]   breq_addr_q, dem_addr_q, pf_addr_q;
  logic            breq_dem_q, drop_q, dem_pend_q, stream_q;
  logic            rsp_valid_q;
  logic [DW-1:0]   rsp_data_q;
  logic [CNTW-1:0] count;
  logic            hit;
  logic [DW-1:0]   hit_data;
  logic            pf_in_flight, dem_in_flight;
  logic            accept, acc_hit, acc_miss, ret, push_en;
  logic            launch_dem, launch_pf;

  pfb_ctl_reg #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .flush_done(flush_done), .hold(hold), .flush_pend(flush_pend),
    .rd_data(ctl_rd_data)
  );

  assign pf_in_flight  = (st_q != BUS_IDLE) && !breq_dem_q;
  assign dem_in_flight = (st_q != BUS_IDLE) && breq_dem_q;
  assign flush_done    = flush_pend && !pf_in_flight;

  assign req_ready = !rsp_valid_q && !dem_pend_q && !dem_in_flight && !flush_pend;
  assign accept    = req_valid && req_ready;
  assign acc_hit   = accept && hit;
  assign acc_miss  = accept && !hit;
  assign ret       = (st_q == BUS_WAIT) && bus_rsp_valid;
  assign push_en   = ret && !breq_dem_q && !drop_q && !acc_miss && !flush_pend;

  assign launch_dem = (st_q == BUS_IDLE) && dem_pend_q;
  assign launch_pf  = (st_q == BUS_IDLE) && !dem_pend_q && stream_q && !hold &&
                      !flush_pend && !ctl_wr_en && !accept &&
                      (count < CNTW'(DEPTH));

  pfb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_pend || acc_miss),
    .lookup_addr(req_addr), .pop_en(acc_hit),
    .push_en(push_en), .push_addr(breq_addr_q), .push_data(bus_rsp_data),
    .hit(hit), .hit_data(hit_data), .count(count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= BUS_IDLE;
      breq_addr_q <= '0;
      breq_dem_q  <= 1'b0;
      drop_q      <= 1'b0;
      dem_pend_q  <= 1'b0;
      dem_addr_q  <= '0;
      pf_addr_q   <= '0;
      stream_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;

      unique case (st_q)
        BUS_IDLE: begin
          if (launch_dem) begin
            st_q        <= BUS_REQ;
            breq_addr_q <= dem_addr_q;
            breq_dem_q  <= 1'b1;
            dem_pend_q  <= 1'b0;
          end else if (launch_pf) begin
            st_q        <= BUS_REQ;
            breq_addr_q <= pf_addr_q;
            breq_dem_q  <= 1'b0;
            pf_addr_q   <= pf_addr_q + AW'(1);
          end
        end
        BUS_REQ:  if (bus_req_ready) st_q <= BUS_WAIT;
        BUS_WAIT: begin
          if (bus_rsp_valid) begin
            st_q <= BUS_IDLE;
            if (breq_dem_q) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= bus_rsp_data;
            end
          end
        end
        default: st_q <= BUS_IDLE;
      endcase

      if (ret) drop_q <= 1'b0;
      else if ((acc_miss || flush_pend) && pf_in_flight) drop_q <= 1'b1;

      if (flush_pend) stream_q <= 1'b0;

      if (acc_hit) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= hit_data;
        stream_q    <= 1'b1;
      end else if (acc_miss) begin
        dem_pend_q  <= 1'b1;
        dem_addr_q  <= req_addr;
        pf_addr_q   <= req_addr + AW'(1);
        stream_q    <= 1'b1;
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign bus_req_valid = (st_q == BUS_REQ);
  assign bus_req_addr  = breq_addr_q;
  assign bus_rsp_ready = (st_q == BUS_WAIT);
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker
  import pfb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_req_valid,
  input logic                       bus_req_ready,
  input logic [AW-1:0]              bus_req_addr,
  input logic                       bus_rsp_ready,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [DW-1:0]              rsp_data,
  input logic [CW-1:0]              ctl_rd_data,
  input logic                       breq_dem,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  a_r2_bus_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr));

  a_r12_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_ready |-> !bus_req_valid);

  a_r5_hold_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) && ctl_rd_data[CTL_HOLD_BIT] |-> breq_dem);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_data[CTL_FLUSH_BIT] |=> count == '0);
endmodule

bind pfb_ctrl_top pfb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_pfb_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_addr(bus_req_addr), .bus_rsp_ready(bus_rsp_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .ctl_rd_data(ctl_rd_data), .breq_dem(breq_dem_q), .count(count)
);

// File: tb/test_pfb_ctrl_top.sv
`timescale 1ns/1ps
module test_pfb_ctrl_top;
  localparam int AW = 16, DW = 32, DEPTH = 4, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr_en = 1'b0;
  logic [CW-1:0] ctl_wr_data = '0, ctl_rd_data;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic bus_req_valid, bus_req_ready = 1'b1;
  logic [AW-1:0] bus_req_addr;
  logic bus_rsp_valid = 1'b0, bus_rsp_ready;
  logic [DW-1:0] bus_rsp_data = '0;

  int n_cmp = 0, n_bad = 0;
  int bus_cnt = 0, bus_lat = 2;

  always #2.5 clk = ~clk;

  pfb_ctrl_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) i_pfb_ctrl_top (.*);

  function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  // Bus memory model, driven away from the active edge.
  logic          pend = 1'b0;
  int            timer = 0;
  logic [AW-1:0] lat_addr = '0;
  always @(negedge clk) begin
    if (bus_rsp_valid) bus_rsp_valid <= 1'b0;
    else if (pend) begin
      if (timer == 0) begin
        bus_rsp_valid <= 1'b1;
        bus_rsp_data  <= mem(lat_addr);
        pend          <= 1'b0;
      end else timer <= timer - 1;
    end
    if (bus_req_valid && !pend) begin
      pend     <= 1'b1;
      lat_addr <= bus_req_addr;
      timer    <= bus_lat;
      bus_cnt  <= bus_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [CW-1:0] v);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
  endtask

  // Returns data and the number of cycles waited after acceptance (0 = hit).
  task automatic demand(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    d = rsp_data;
  endtask

  // Row: kind(2) 0=demand 1=ctl write | value(16) | expect hit(1) | expect read-back(8) | bus reads over row(5)
  localparam logic [31:0] TBL [0:12] = '{
    {2'd0, 16'h0100, 1'b0, 8'h00, 5'd5}, // R2 miss, R4 fills four
    {2'd0, 16'h0101, 1'b1, 8'h00, 5'd1}, // R3 hit, one refill
    {2'd0, 16'h0103, 1'b1, 8'h00, 5'd2}, // R3 hit pops two
    {2'd1, 16'h0001, 1'b0, 8'h01, 5'd0}, // R5 hold on
    {2'd0, 16'h0104, 1'b1, 8'h00, 5'd0}, // R6 hit under hold, no refill
    {2'd0, 16'h0105, 1'b1, 8'h00, 5'd0}, // R6
    {2'd1, 16'h0003, 1'b0, 8'h01, 5'd0}, // R9 hold+flush together
    {2'd0, 16'h0106, 1'b0, 8'h00, 5'd1}, // R7 miss after flush, R5 demand only
    {2'd0, 16'h0107, 1'b0, 8'h00, 5'd1}, // R5 nothing prefetched
    {2'd1, 16'h0000, 1'b0, 8'h00, 5'd4}, // R4 resume fills 108..10B
    {2'd0, 16'h010A, 1'b1, 8'h00, 5'd3}, // R3 hit pops three
    {2'd0, 16'h0200, 1'b0, 8'h00, 5'd5}, // R13 non-sequential miss
    {2'd0, 16'h0201, 1'b1, 8'h00, 5'd1}  // R13 restarted stream hits
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int lat, b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctl read-back", DW'(ctl_rd_data), 32'h0);
    check("R1 req_ready", DW'(req_ready), 32'h1);
    check("R1 bus_req_valid", DW'(bus_req_valid), 32'h0);
    check("R1 rsp_valid", DW'(rsp_valid), 32'h0);

    for (int i = 0; i < 13; i++) begin
      logic [31:0] e;
      e  = TBL[i];
      b0 = bus_cnt;
      if (e[31:30] == 2'd0) begin
        demand(e[29:14], d, lat);
        check($sformatf("R2 data row %0d", i), d, mem(e[29:14]));
        check($sformatf("R3 hit row %0d", i), DW'(lat == 0), DW'(e[13]));
      end else begin
        ctl_write(e[21:14]);
      end
      repeat (40) @(negedge clk);
      if (e[31:30] == 2'd1)
        check($sformatf("R9 read-back row %0d", i), DW'(ctl_rd_data), DW'(e[12:5]));
      check($sformatf("R4 bus reads row %0d", i), DW'(bus_cnt - b0), DW'(e[4:0]));
    end

    // R11 reserved bits
    ctl_write(8'hFC);
    check("R11 reserved read 0", DW'(ctl_rd_data), 32'h0);
    ctl_write(8'hFD);
    check("R11 reserved with hold", DW'(ctl_rd_data), 32'h1);
    ctl_write(8'h00);

    // R8 / R10: flush while a prefetch read is outstanding
    bus_lat = 12;
    demand(16'h0300, d, lat);
    check("R2 slow miss data", d, mem(16'h0300));
    repeat (3) @(negedge clk);
    ctl_write(8'h03);
    check("R8 flush pending", DW'(ctl_rd_data[1]), 32'h1);
    repeat (3) @(negedge clk);
    check("R8 still pending in flight", DW'(ctl_rd_data[1]), 32'h1);
    for (int k = 0; k < 40 && ctl_rd_data[1]; k++) @(negedge clk);
    check("R8 flush self-cleared", DW'(ctl_rd_data), 32'h1);
    ctl_write(8'h00);
    bus_lat = 2;
    b0 = bus_cnt;
    repeat (20) @(negedge clk);
    check("R7 no prefetch before demand", DW'(bus_cnt - b0), 32'h0);
    demand(16'h0301, d, lat);
    check("R10 discarded word misses", DW'(lat == 0), 32'h0);
    check("R10 data", d, mem(16'h0301));

    // R12 response back-pressure
    repeat (40) @(negedge clk);
    rsp_ready = 1'b0;
    demand(16'h0302, d, lat);
    check("R3 hit latency", DW'(lat), 32'h0);
    repeat (3) @(negedge clk);
    check("R12 valid held", DW'(rsp_valid), 32'h1);
    check("R12 data held", rsp_data, mem(16'h0302));
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 released", DW'(rsp_valid), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule